// File: doc/BRIEF.md
# CAN Node Error Counter and Fault-State Tracker

This block keeps the transmit and receive error counters of a CAN node and derives the node's fault state from them: a warning flag against a programmable threshold, the error-passive condition, and bus-off. The protocol engine does not hand it raw bus bits. It receives one-cycle strobes instead: an error event carrying a 2-bit kind, a direction and a 5-bit frame-segment position, and success strobes for a completed transmission or reception.

Software configures the block through a small write port. The warning threshold and both counters can be written only while the node is in reset mode. Reset mode is in force when the software mode input asks for it, and it is also forced by bus-off. In listen-only mode the node observes the bus without affecting it, so both counters keep their values. The first error seen after a read of the capture register is latched with its kind, direction and segment and held for software. Later errors are dropped until the next read.

Top module: `can_err_tracker`

## Requirements
- R1: After synchronous reset both counters read 0, the warning limit reads 96, and warn, passive, bus-off and capture-valid all read 0.
- R2: Outside reset mode and listen-only mode, an error event with direction 0 (transmit) adds 8 to the transmit counter. An error event with direction 1 (receive) adds 1 to the receive counter, which saturates at 255.
- R3: A transmit-success or receive-success strobe takes 1 from the matching counter and never takes it below 0. If an error on the same counter arrives in the same cycle, the error is applied and the success strobe is ignored.
- R4: The warn output is 1 exactly when either counter is greater than or equal to the warning limit.
- R5: The passive output is 1 exactly when either counter is greater than 127.
- R6: While listen-only mode is selected and the node is not in reset mode, error and success strobes leave both counters unchanged.
- R7: Writes take effect only in reset mode. The select encoding is 0 for the warning limit, 1 for the receive counter, 2 for the transmit counter and 3 for no register. A write outside reset mode changes nothing. Error and success strobes in reset mode leave the counters unchanged.
- R8: A transmit error that would take the transmit counter above 255 sets bus-off and leaves the transmit counter at 255. While bus-off is set, the node is in reset mode. A write to the transmit counter clears bus-off.
- R9: The capture code is formatted as bits [7:6] kind (00 bit, 01 form, 10 stuff, 11 other), bit [5] direction (1 receive, 0 transmit) and bits [4:0] segment. The first error seen outside reset mode while capture-valid is 0 is latched and sets capture-valid. A read strobe clears capture-valid, unless an error arrives in the same cycle, in which case that error is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_reset | input | 1 | Software request for reset mode |
| mode_listen | input | 1 | Listen-only mode select |
| evt_err | input | 1 | Error event strobe |
| evt_kind | input | 2 | Error kind of the event |
| evt_dir | input | 1 | Error direction, 1 receive, 0 transmit |
| evt_seg | input | 5 | Frame segment in which the error occurred |
| evt_tx_ok | input | 1 | Successful transmission strobe |
| evt_rx_ok | input | 1 | Successful reception strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target select |
| cfg_wdata | input | 8 | Write data |
| cap_rd | input | 1 | Capture register read strobe |
| tx_cnt | output | 8 | Transmit error counter |
| rx_cnt | output | 8 | Receive error counter |
| warn_limit | output | 8 | Current warning threshold |
| st_warn | output | 1 | Either counter at or above the threshold |
| st_passive | output | 1 | Either counter above 127 |
| st_bus_off | output | 1 | Node has left bus traffic |
| in_reset_mode | output | 1 | Effective reset mode (request or bus-off) |
| cap_code | output | 8 | Captured error code |
| cap_valid | output | 1 | Capture holds an unread error |

## Verification
The case hardest to reach from the ports is bus-off at its exact boundary. Counting up from zero with transmit errors alone lands only on multiples of 8, so the bench writes the transmit counter to 247 and 248 in reset mode, leaves reset mode, and sends one transmit error to show that 255 is still bus-on and 256 is bus-off. A second hard case is a read strobe in the same cycle as an error. A long mixed stream of strobes, mode changes and writes produces it many times, and every output is compared each cycle against an arithmetic model. A sweep of threshold and counter values written in reset mode covers the warning comparison on both sides of equality.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    localparam int SEG_W  = 5;
    localparam int CODE_W = 2 + 1 + SEG_W;

    typedef enum logic [1:0] {
        KIND_BIT   = 2'b00,
        KIND_FORM  = 2'b01,
        KIND_STUFF = 2'b10,
        KIND_OTHER = 2'b11
    } err_kind_e;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } err_dir_e;

    typedef enum logic [1:0] {
        SEL_LIMIT = 2'd0,
        SEL_RXCNT = 2'd1,
        SEL_TXCNT = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    // kind lands in the top two bits, direction below it, segment at the bottom
    typedef struct packed {
        err_kind_e        kind;
        err_dir_e         dir;
        logic [SEG_W-1:0] seg;
    } err_code_t;

    function automatic err_code_t pack_code(input logic [1:0] kind,
                                            input logic dir,
                                            input logic [SEG_W-1:0] seg);
        err_code_t c;
        c.kind = err_kind_e'(kind);
        c.dir  = err_dir_e'(dir);
        c.seg  = seg;
        return c;
    endfunction

endpackage

// File: rtl/can_err_counter.sv
module can_err_counter #(
    parameter int CNT_W = 8,
    parameter int INC   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frozen,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             err_hit,
    input  logic             ok_hit,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W:0] MAX_W = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W:0] INC_W = (CNT_W+1)'(INC);

    logic [CNT_W:0] sum;
    assign sum = {1'b0, cnt} + INC_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (!frozen) begin
            if (err_hit) begin
                cnt <= (sum > MAX_W) ? MAX_W[CNT_W-1:0] : sum[CNT_W-1:0];
            end else if (ok_hit && (cnt != '0)) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/can_err_status.sv
module can_err_status #(
    parameter int CNT_W       = 8,
    parameter int PASSIVE_LVL = 127
) (
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] limit,
    output logic             warn,
    output logic             passive
);
    localparam logic [CNT_W-1:0] LVL = CNT_W'(PASSIVE_LVL);

    always_comb begin
        warn    = (tx_cnt >= limit) || (rx_cnt >= limit);
        passive = (tx_cnt > LVL) || (rx_cnt > LVL);
    end
endmodule

// File: rtl/can_err_capture.sv
module can_err_capture
    import can_err_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      err_hit,
    input  err_code_t code_in,
    input  logic      rd,
    output err_code_t code,
    output logic      valid
);
    logic take;
    assign take = enable && err_hit && (!valid || rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            code  <= '0;
            valid <= 1'b0;
        end else if (take) begin
            code  <= code_in;
            valid <= 1'b1;
        end else if (rd) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/can_err_tracker.sv
module can_err_tracker
    import can_err_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int TX_ERR_INC  = 8,
    parameter int RX_ERR_INC  = 1,
    parameter int PASSIVE_LVL = 127,
    parameter int WARN_RESET  = 96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_reset,
    input  logic              mode_listen,
    input  logic              evt_err,
    input  logic [1:0]        evt_kind,
    input  logic              evt_dir,
    input  logic [SEG_W-1:0]  evt_seg,
    input  logic              evt_tx_ok,
    input  logic              evt_rx_ok,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CNT_W-1:0]  cfg_wdata,
    input  logic              cap_rd,
    output logic [CNT_W-1:0]  tx_cnt,
    output logic [CNT_W-1:0]  rx_cnt,
    output logic [CNT_W-1:0]  warn_limit,
    output logic              st_warn,
    output logic              st_passive,
    output logic              st_bus_off,
    output logic              in_reset_mode,
    output logic [CODE_W-1:0] cap_code,
    output logic              cap_valid
);
    localparam int N_CNT = 2;
    localparam int IDX_TX = 0;
    localparam int IDX_RX = 1;
    localparam logic [CNT_W:0] MAX_W = {1'b0, {CNT_W{1'b1}}};

    logic             eff_reset;
    logic             frozen;
    logic             bus_off_q;
    logic [CNT_W-1:0] limit_q;
    logic             tx_wrap;

    logic             c_load [N_CNT];
    logic             c_err  [N_CNT];
    logic             c_ok   [N_CNT];
    logic [CNT_W-1:0] c_val  [N_CNT];

    err_code_t        code_in;
    err_code_t        code_q;

    assign eff_reset = mode_reset || bus_off_q;
    assign frozen    = eff_reset || mode_listen;

    always_comb begin
        c_load[IDX_TX] = eff_reset && cfg_we && (cfg_sel_e'(cfg_sel) == SEL_TXCNT);
        c_load[IDX_RX] = eff_reset && cfg_we && (cfg_sel_e'(cfg_sel) == SEL_RXCNT);
        c_err[IDX_TX]  = evt_err && (err_dir_e'(evt_dir) == DIR_TX);
        c_err[IDX_RX]  = evt_err && (err_dir_e'(evt_dir) == DIR_RX);
        c_ok[IDX_TX]   = evt_tx_ok;
        c_ok[IDX_RX]   = evt_rx_ok;
    end

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        localparam int STEP = (g == IDX_TX) ? TX_ERR_INC : RX_ERR_INC;
        can_err_counter #(
            .CNT_W (CNT_W),
            .INC   (STEP)
        ) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .frozen   (frozen),
            .load     (c_load[g]),
            .load_val (cfg_wdata),
            .err_hit  (c_err[g]),
            .ok_hit   (c_ok[g]),
            .cnt      (c_val[g])
        );
    end

    // transmit error that would carry the counter past its ceiling
    assign tx_wrap = !frozen && c_err[IDX_TX] &&
                     (({1'b0, c_val[IDX_TX]} + (CNT_W+1)'(TX_ERR_INC)) > MAX_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_off_q <= 1'b0;
        end else if (c_load[IDX_TX]) begin
            bus_off_q <= 1'b0;
        end else if (tx_wrap) begin
            bus_off_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= CNT_W'(WARN_RESET);
        end else if (eff_reset && cfg_we && (cfg_sel_e'(cfg_sel) == SEL_LIMIT)) begin
            limit_q <= cfg_wdata;
        end
    end

    can_err_status #(
        .CNT_W       (CNT_W),
        .PASSIVE_LVL (PASSIVE_LVL)
    ) u_status (
        .tx_cnt  (c_val[IDX_TX]),
        .rx_cnt  (c_val[IDX_RX]),
        .limit   (limit_q),
        .warn    (st_warn),
        .passive (st_passive)
    );

    assign code_in = pack_code(evt_kind, evt_dir, evt_seg);

    can_err_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .enable  (!eff_reset),
        .err_hit (evt_err),
        .code_in (code_in),
        .rd      (cap_rd),
        .code    (code_q),
        .valid   (cap_valid)
    );

    assign tx_cnt        = c_val[IDX_TX];
    assign rx_cnt        = c_val[IDX_RX];
    assign warn_limit    = limit_q;
    assign st_bus_off    = bus_off_q;
    assign in_reset_mode = eff_reset;
    assign cap_code      = code_q;
endmodule

// File: rtl/can_err_tracker_chk.sv
module can_err_tracker_chk #(
    parameter int CNT_W      = 8,
    parameter int TX_ERR_INC = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_listen,
    input logic             evt_err,
    input logic             evt_tx_ok,
    input logic             evt_rx_ok,
    input logic             cap_rd,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [CNT_W-1:0] warn_limit,
    input logic             st_bus_off,
    input logic             in_reset_mode,
    input logic [7:0]       cap_code,
    input logic             cap_valid
);
    // R6: listen-only outside reset mode freezes both counters
    a_r6_listen_freeze: assert property (@(posedge clk) disable iff (rst)
        (mode_listen && !in_reset_mode) |=> ($stable(tx_cnt) && $stable(rx_cnt)));

    // R7: nothing configurable changes in operating mode without events
    a_r7_no_write_in_operating: assert property (@(posedge clk) disable iff (rst)
        (!in_reset_mode && !evt_err && !evt_tx_ok && !evt_rx_ok)
        |=> ($stable(tx_cnt) && $stable(rx_cnt) && $stable(warn_limit)));

    // R7: threshold only moves in reset mode
    a_r7_limit_locked: assert property (@(posedge clk) disable iff (rst)
        !in_reset_mode |=> $stable(warn_limit));

    // R8: bus-off always forces reset mode
    a_r8_busoff_forces_reset: assert property (@(posedge clk) disable iff (rst)
        st_bus_off |-> in_reset_mode);

    // R8: entering bus-off leaves the transmit counter at its ceiling
    a_r8_busoff_at_ceiling: assert property (@(posedge clk) disable iff (rst)
        $rose(st_bus_off) |-> (tx_cnt == {CNT_W{1'b1}}));

    // R2: operating-mode transmit counter never jumps by more than one error step
    a_r2_tx_step_bound: assert property (@(posedge clk) disable iff (rst)
        !in_reset_mode |=> ({1'b0, tx_cnt} <= ({1'b0, $past(tx_cnt)} + (CNT_W+1)'(TX_ERR_INC))));

    // R3: operating-mode receive counter never drops by more than one
    a_r3_rx_step_bound: assert property (@(posedge clk) disable iff (rst)
        !in_reset_mode |=> (({1'b0, rx_cnt} + 1'b1) >= {1'b0, $past(rx_cnt)}));

    // R9: an unread capture is held
    a_r9_capture_holds: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !cap_rd) |=> ($stable(cap_code) && cap_valid));
endmodule

bind can_err_tracker can_err_tracker_chk #(
    .CNT_W      (CNT_W),
    .TX_ERR_INC (TX_ERR_INC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_listen   (mode_listen),
    .evt_err       (evt_err),
    .evt_tx_ok     (evt_tx_ok),
    .evt_rx_ok     (evt_rx_ok),
    .cap_rd        (cap_rd),
    .tx_cnt        (tx_cnt),
    .rx_cnt        (rx_cnt),
    .warn_limit    (warn_limit),
    .st_bus_off    (st_bus_off),
    .in_reset_mode (in_reset_mode),
    .cap_code      (cap_code),
    .cap_valid     (cap_valid)
);

// File: tb/can_err_tracker_bench.sv
module can_err_tracker_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_reset = 1'b1;
    logic       mode_listen = 1'b0;
    logic       evt_err = 1'b0;
    logic [1:0] evt_kind = 2'd0;
    logic       evt_dir = 1'b0;
    logic [4:0] evt_seg = 5'd0;
    logic       evt_tx_ok = 1'b0;
    logic       evt_rx_ok = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd3;
    logic [7:0] cfg_wdata = 8'd0;
    logic       cap_rd = 1'b0;

    logic [7:0] tx_cnt, rx_cnt, warn_limit, cap_code;
    logic       st_warn, st_passive, st_bus_off, in_reset_mode, cap_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference state
    int  m_tx, m_rx, m_lim;
    bit  m_boff, m_capv;
    logic [7:0] m_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_err_tracker u_can_err_tracker (
        .clk(clk), .rst(rst), .mode_reset(mode_reset), .mode_listen(mode_listen),
        .evt_err(evt_err), .evt_kind(evt_kind), .evt_dir(evt_dir), .evt_seg(evt_seg),
        .evt_tx_ok(evt_tx_ok), .evt_rx_ok(evt_rx_ok), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cap_rd(cap_rd), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .warn_limit(warn_limit), .st_warn(st_warn), .st_passive(st_passive),
        .st_bus_off(st_bus_off), .in_reset_mode(in_reset_mode), .cap_code(cap_code),
        .cap_valid(cap_valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_tx = 0; m_rx = 0; m_lim = 96; m_boff = 0; m_capv = 0; m_code = 8'd0;
    endtask

    // arithmetic model of one clock edge, from the requirements
    task automatic model_step();
        bit eff;
        eff = mode_reset || m_boff;
        if (eff) begin
            if (cfg_we) begin
                if (cfg_sel == 2'd0) m_lim = cfg_wdata;
                if (cfg_sel == 2'd1) m_rx = cfg_wdata;
                if (cfg_sel == 2'd2) begin m_tx = cfg_wdata; m_boff = 0; end
            end
        end else if (!mode_listen) begin
            if (evt_err && !evt_dir) begin
                if (m_tx + 8 > 255) begin m_tx = 255; m_boff = 1; end
                else m_tx = m_tx + 8;
            end else if (evt_tx_ok && m_tx > 0) m_tx = m_tx - 1;
            if (evt_err && evt_dir) m_rx = (m_rx + 1 > 255) ? 255 : m_rx + 1;
            else if (evt_rx_ok && m_rx > 0) m_rx = m_rx - 1;
        end
        if (!eff && evt_err && (!m_capv || cap_rd)) begin
            m_code = {evt_kind, evt_dir, evt_seg};
            m_capv = 1;
        end else if (cap_rd) m_capv = 0;
    endtask

    task automatic compare_all();
        check("R2/R3 tx_cnt", tx_cnt, m_tx);
        check("R2/R3 rx_cnt", rx_cnt, m_rx);
        check("R7 warn_limit", warn_limit, m_lim);
        check("R4 st_warn", st_warn, (m_tx >= m_lim || m_rx >= m_lim));
        check("R5 st_passive", st_passive, (m_tx > 127 || m_rx > 127));
        check("R8 st_bus_off", st_bus_off, m_boff);
        check("R8 in_reset_mode", in_reset_mode, (mode_reset || m_boff));
        check("R9 cap_valid", cap_valid, m_capv);
        if (m_capv) check("R9 cap_code", cap_code, m_code);
    endtask

    // inputs already set after a negedge; apply one edge and compare after it
    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare_all();
        @(negedge clk);
        evt_err = 0; evt_tx_ok = 0; evt_rx_ok = 0; cfg_we = 0; cap_rd = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        tick();
    endtask

    task automatic err(input logic dir, input logic [1:0] k, input logic [4:0] s);
        evt_err = 1; evt_dir = dir; evt_kind = k; evt_seg = s;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check("R1 tx_cnt", tx_cnt, 0);
        check("R1 rx_cnt", rx_cnt, 0);
        check("R1 warn_limit", warn_limit, 96);
        check("R1 flags", {st_warn, st_passive, st_bus_off, cap_valid}, 0);

        // R4 sweep of threshold against written counter values (reset mode)
        for (int l = 0; l < 256; l += 15) begin
            wr(2'd0, l[7:0]);
            for (int v = 0; v < 256; v += 17) begin
                wr(2'd1, v[7:0]);
                wr(2'd2, 8'(255 - v));
            end
        end
        // R5 passive boundary
        wr(2'd1, 8'd0);
        wr(2'd2, 8'd127); check("R5 at 127", st_passive, 0);
        wr(2'd2, 8'd128); check("R5 at 128", st_passive, 1);
        wr(2'd0, 8'd96);

        // R7 events in reset mode ignored
        err(1'b0, 2'd0, 5'd3);
        check("R7 tx held in reset", tx_cnt, 128);
        check("R7 no capture in reset", cap_valid, 0);

        // R7 write in operating mode ignored
        mode_reset = 0;
        wr(2'd2, 8'd5);
        check("R7 op write ignored", tx_cnt, 128);

        // R3 error beats success on same counter
        evt_tx_ok = 1; err(1'b0, 2'd2, 5'd9);
        check("R3 err wins", tx_cnt, 136);
        check("R9 kind stuff tx", cap_code, {2'b10, 1'b0, 5'd9});
        // R9 later error dropped, read with simultaneous error captures it
        err(1'b1, 2'd1, 5'd4);
        check("R9 held first", cap_code, {2'b10, 1'b0, 5'd9});
        cap_rd = 1; err(1'b1, 2'd3, 5'd17);
        check("R9 read+err", cap_code, {2'b11, 1'b1, 5'd17});
        cap_rd = 1; tick();
        check("R9 read clears", cap_valid, 0);

        // R6 listen-only freeze
        mode_listen = 1;
        err(1'b0, 2'd0, 5'd1);
        evt_rx_ok = 1; evt_tx_ok = 1; tick();
        check("R6 tx frozen", tx_cnt, 136);
        mode_listen = 0;

        // R8 boundary: 247+8=255 stays on bus, 248+8 goes off
        mode_reset = 1;
        wr(2'd2, 8'd247);
        mode_reset = 0;
        err(1'b0, 2'd0, 5'd2);
        check("R8 255 still on", st_bus_off, 0);
        mode_reset = 1;
        wr(2'd2, 8'd248);
        mode_reset = 0;
        err(1'b0, 2'd0, 5'd2);
        check("R8 256 off", st_bus_off, 1);
        check("R8 forced reset", in_reset_mode, 1);
        check("R8 tx ceiling", tx_cnt, 255);
        wr(2'd2, 8'd0);
        check("R8 cleared by write", st_bus_off, 0);

        // mixed stream compared every cycle against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            mode_reset  = (r < 6);
            mode_listen = ($urandom_range(0, 99) < 8);
            evt_err     = ($urandom_range(0, 99) < 45);
            evt_dir     = ($urandom_range(0, 99) < 35);
            evt_kind    = 2'($urandom_range(0, 3));
            evt_seg     = 5'($urandom_range(0, 31));
            evt_tx_ok   = ($urandom_range(0, 99) < 50);
            evt_rx_ok   = ($urandom_range(0, 99) < 40);
            cap_rd      = ($urandom_range(0, 99) < 20);
            cfg_we      = ($urandom_range(0, 99) < 30);
            cfg_sel     = 2'($urandom_range(0, 3));
            cfg_wdata   = 8'($urandom_range(0, 255));
            tick();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule